// File: doc/BRIEF.md
# Bus Controller Timer, Timestamp and Event Interrupt Unit

This unit holds the interrupt and status logic of a message-bus controller. A free-running 16-bit timer advances on a prescaled bit-time tick. On a frame boundary the unit copies the timer into a timestamp register. A configuration input selects whether that boundary is the start or the end of a frame.

Five event sources feed a status word: timer wrap, timestamp capture, error warning, sleep entry and wake-up. The two timer-related bits latch and stay set until software reads the status word. The other three bits follow their source condition and ignore a read. A mask register, written through separate set and clear strobes, selects which status bits drive the single interrupt line.

Top module: `evtirq_status`

## Requirements
- R1: The timer advances by one each time the prescaler ticks. A tick occurs every presc_i+1 clocks. The timer wraps from 16'hFFFF to 0.
- R2: Status bit 3 (overflow) is set in the cycle after the timer wraps.
- R3: When ts_on_eof_i is 0, a pulse on sof_i captures the timer into timestamp_o and sets status bit 4. When ts_on_eof_i is 1, eof_i does this instead, and a pulse on the unselected input has no effect.
- R4: A stat_rd_i strobe clears status bits 3 and 4. If a new overflow or capture event arrives in the same cycle as the strobe, its bit stays set.
- R5: Status bit 0 (warning) is 1 one cycle after err_active_i is high and tec_i or rec_i is greater than 96. Otherwise the bit is 0, and stat_rd_i does not affect it.
- R6: Status bit 2 (sleep) is 1 one cycle after lp_req_i is high while tx_pend_i is low. It drops when either condition goes away, and stat_rd_i does not affect it.
- R7: Status bit 1 (wake) is set by a bus_sync_i pulse only if a wakeup_i pulse came earlier. A bus_sync_i pulse with no prior wakeup_i is ignored. The bit clears when lp_req_i is raised, and stat_rd_i does not affect it.
- R8: A 1 on bit i of imr_set_i sets mask bit i, and a 1 on bit i of imr_clr_i clears it. If both strobes hit the same bit in the same cycle, the clear wins.
- R9: irq_o is the OR of (status_o AND imr_o).
- R10: After reset, status_o, imr_o, timestamp_o and timer_o are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| presc_i | input | 8 | Prescaler divide value minus one |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| ts_on_eof_i | input | 1 | 1: capture the timestamp on end of frame; 0: capture on start of frame |
| tec_i | input | 9 | Transmit error count |
| rec_i | input | 9 | Receive error count |
| err_active_i | input | 1 | Node is error-active |
| lp_req_i | input | 1 | Low-power mode requested |
| tx_pend_i | input | 1 | Transmit messages still pending |
| wakeup_i | input | 1 | Wake-up detected pulse |
| bus_sync_i | input | 1 | Bus synchronised pulse |
| stat_rd_i | input | 1 | Status read strobe |
| imr_set_i | input | 5 | Write-one-to-set strobes for the mask |
| imr_clr_i | input | 5 | Write-one-to-clear strobes for the mask |
| status_o | output | 5 | Status: bit 0 warn, bit 1 wake, bit 2 sleep, bit 3 overflow, bit 4 timestamp |
| timestamp_o | output | 16 | Captured timer value |
| timer_o | output | 16 | Current timer value |
| imr_o | output | 5 | Interrupt mask |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- the timer holds between ticks and wraps to zero;
- a wrap or a capture sets its sticky bit;
- a read with no new event clears the sticky bits;
- the captured value equals the timer value at the moment of capture;
- a clear strobe always empties the mask bit;
- the warn and sleep bits drop when their qualifying input is absent.

Some behaviours only the bench scenarios can show:
- the error-count threshold at 96 against 97 on each counter;
- the two-step wakeup-then-sync order;
- that an unselected frame edge leaves the timestamp unchanged;
- the prescaler tick rate;
- that a read has no effect on the level-following bits.

// File: rtl/evtirq_pkg.sv
`timescale 1ns/1ps
package evtirq_pkg;
  localparam int NUM_IRQ   = 5;
  localparam int IDX_WARN  = 0;
  localparam int IDX_WAKE  = 1;
  localparam int IDX_SLEEP = 2;
  localparam int IDX_OVF   = 3;
  localparam int IDX_TSTP  = 4;
  // bits that latch and clear on status read
  localparam logic [NUM_IRQ-1:0] RD_CLR_MASK = 5'b11000;
endpackage

// File: rtl/evtirq_timer.sv
`timescale 1ns/1ps
module evtirq_timer #(
  parameter int TMR_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] presc_i,
  output logic [TMR_W-1:0] timer_o,
  output logic             wrap_o
);
  logic [PSC_W-1:0] psc_q;
  logic [TMR_W-1:0] tmr_q;
  logic             tick;

  assign tick = (psc_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      tmr_q <= '0;
    end else begin
      psc_q <= tick ? '0 : psc_q + 1'b1;
      if (tick) tmr_q <= tmr_q + 1'b1;
    end
  end

  assign timer_o = tmr_q;
  assign wrap_o  = tick && (&tmr_q);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(tmr_q));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (&tmr_q)) |=> (tmr_q == '0));
endmodule

// File: rtl/evtirq_capture.sv
`timescale 1ns/1ps
module evtirq_capture #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             sel_eof_i,
  input  logic [TMR_W-1:0] timer_i,
  output logic [TMR_W-1:0] stamp_o,
  output logic             cap_o
);
  logic [TMR_W-1:0] stamp_q;

  assign cap_o = sel_eof_i ? eof_i : sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stamp_q <= '0;
    else if (cap_o) stamp_q <= timer_i;
  end

  assign stamp_o = stamp_q;

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> (stamp_q == $past(timer_i)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_o |=> $stable(stamp_q));
endmodule

// File: rtl/evtirq_cond.sv
`timescale 1ns/1ps
module evtirq_cond #(
  parameter int ERR_W    = 9,
  parameter int WARN_LIM = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] tec_i,
  input  logic [ERR_W-1:0] rec_i,
  input  logic             err_active_i,
  input  logic             lp_req_i,
  input  logic             tx_pend_i,
  input  logic             wakeup_i,
  input  logic             bus_sync_i,
  output logic             warn_o,
  output logic             sleep_o,
  output logic             wake_o
);
  localparam logic [ERR_W-1:0] LIM = ERR_W'(WARN_LIM);

  logic warn_q, sleep_q, wake_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q  <= 1'b0;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      warn_q  <= err_active_i && ((tec_i > LIM) || (rec_i > LIM));
      sleep_q <= lp_req_i && !tx_pend_i;
      // wake needs wakeup first, then bus sync; a new low-power request drops it
      if (lp_req_i)        armed_q <= 1'b0;
      else if (wakeup_i)   armed_q <= 1'b1;
      else if (bus_sync_i) armed_q <= 1'b0;
      if (lp_req_i)                    wake_q <= 1'b0;
      else if (bus_sync_i && armed_q)  wake_q <= 1'b1;
    end
  end

  assign warn_o  = warn_q;
  assign sleep_o = sleep_q;
  assign wake_o  = wake_q;

  a_r5_warn_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_active_i |=> !warn_q);
  a_r6_sleep_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pend_i |=> !sleep_q);
  a_r7_wake_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_req_i |=> !wake_q);
endmodule

// File: rtl/evtirq_mask.sv
`timescale 1ns/1ps
module evtirq_mask #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;

  a_r8_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));
endmodule

// File: rtl/evtirq_status.sv
`timescale 1ns/1ps
module evtirq_status
  import evtirq_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int PSC_W    = 8,
  parameter int ERR_W    = 9,
  parameter int WARN_LIM = 96
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PSC_W-1:0]   presc_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               ts_on_eof_i,
  input  logic [ERR_W-1:0]   tec_i,
  input  logic [ERR_W-1:0]   rec_i,
  input  logic               err_active_i,
  input  logic               lp_req_i,
  input  logic               tx_pend_i,
  input  logic               wakeup_i,
  input  logic               bus_sync_i,
  input  logic               stat_rd_i,
  input  logic [NUM_IRQ-1:0] imr_set_i,
  input  logic [NUM_IRQ-1:0] imr_clr_i,
  output logic [NUM_IRQ-1:0] status_o,
  output logic [TMR_W-1:0]   timestamp_o,
  output logic [TMR_W-1:0]   timer_o,
  output logic [NUM_IRQ-1:0] imr_o,
  output logic               irq_o
);
  logic               wrap, cap;
  logic               warn, sleep, wake;
  logic [NUM_IRQ-1:0] src;
  logic [NUM_IRQ-1:0] stat;

  evtirq_timer #(.TMR_W(TMR_W), .PSC_W(PSC_W)) u_timer (
    .clk_i, .rst_ni, .presc_i, .timer_o, .wrap_o(wrap)
  );

  evtirq_capture #(.TMR_W(TMR_W)) u_capture (
    .clk_i, .rst_ni, .sof_i, .eof_i, .sel_eof_i(ts_on_eof_i),
    .timer_i(timer_o), .stamp_o(timestamp_o), .cap_o(cap)
  );

  evtirq_cond #(.ERR_W(ERR_W), .WARN_LIM(WARN_LIM)) u_cond (
    .clk_i, .rst_ni, .tec_i, .rec_i, .err_active_i, .lp_req_i, .tx_pend_i,
    .wakeup_i, .bus_sync_i, .warn_o(warn), .sleep_o(sleep), .wake_o(wake)
  );

  evtirq_mask #(.N(NUM_IRQ)) u_mask (
    .clk_i, .rst_ni, .set_i(imr_set_i), .clr_i(imr_clr_i), .mask_o(imr_o)
  );

  always_comb begin
    src            = '0;
    src[IDX_WARN]  = warn;
    src[IDX_WAKE]  = wake;
    src[IDX_SLEEP] = sleep;
    src[IDX_OVF]   = wrap;
    src[IDX_TSTP]  = cap;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stat
    if (RD_CLR_MASK[i]) begin : g_sticky
      logic flag_q;
      // a new event in the read cycle keeps the bit set
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= src[i] | (flag_q & ~stat_rd_i);
      end
      assign stat[i] = flag_q;
    end else begin : g_level
      assign stat[i] = src[i];
    end
  end

  assign status_o = stat;
  assign irq_o    = |(stat & imr_o);

  a_r2_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> status_o[IDX_OVF]);
  a_r3_tstp_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> status_o[IDX_TSTP]);
  a_r4_rd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !wrap && !cap) |=> (status_o[IDX_OVF] == 1'b0 && status_o[IDX_TSTP] == 1'b0));
endmodule

// File: tb/evtirq_status_tb.sv
`timescale 1ns/1ps
module evtirq_status_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  presc_i = '0;
  logic        sof_i = 0, eof_i = 0, ts_on_eof_i = 0;
  logic [8:0]  tec_i = '0, rec_i = '0;
  logic        err_active_i = 0, lp_req_i = 0, tx_pend_i = 0;
  logic        wakeup_i = 0, bus_sync_i = 0, stat_rd_i = 0;
  logic [4:0]  imr_set_i = '0, imr_clr_i = '0;
  logic [4:0]  status_o, imr_o;
  logic [15:0] timestamp_o, timer_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  evtirq_status u_dut (
    .clk_i(clk), .rst_ni, .presc_i, .sof_i, .eof_i, .ts_on_eof_i,
    .tec_i, .rec_i, .err_active_i, .lp_req_i, .tx_pend_i, .wakeup_i,
    .bus_sync_i, .stat_rd_i, .imr_set_i, .imr_clr_i,
    .status_o, .timestamp_o, .timer_o, .imr_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // {err_active, tec, rec, expected warn}
  localparam logic [19:0] WARN_VEC [7] = '{
    {1'b1, 9'd96,  9'd0,   1'b0},
    {1'b1, 9'd97,  9'd0,   1'b1},
    {1'b1, 9'd0,   9'd97,  1'b1},
    {1'b0, 9'd200, 9'd200, 1'b0},
    {1'b1, 9'd96,  9'd96,  1'b0},
    {1'b1, 9'd511, 9'd0,   1'b1},
    {1'b1, 9'd0,   9'd0,   1'b0}
  };

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] t0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 status", 32'(status_o), 0);
    check("R10 imr", 32'(imr_o), 0);
    check("R10 timestamp", 32'(timestamp_o), 0);
    check("R10 timer", 32'(timer_o), 0);
    check("R10 irq", 32'(irq_o), 0);
    rst_ni = 1'b1;

    // R5 warning threshold table
    for (int i = 0; i < 7; i++) begin
      err_active_i = WARN_VEC[i][19];
      tec_i        = WARN_VEC[i][18:10];
      rec_i        = WARN_VEC[i][9:1];
      step();
      check("R5 warn vector", 32'(status_o[0]), 32'(WARN_VEC[i][0]));
    end
    err_active_i = 1; tec_i = 9'd150;
    step();
    stat_rd_i = 1; step(); stat_rd_i = 0;
    check("R5 warn survives read", 32'(status_o[0]), 1);
    err_active_i = 0; tec_i = 0;
    step();
    check("R5 warn follows source", 32'(status_o[0]), 0);

    // R3 capture on start of frame
    ts_on_eof_i = 0;
    step();
    t0 = timer_o; sof_i = 1;
    step(); sof_i = 0;
    check("R3 sof stamp", 32'(timestamp_o), 32'(t0));
    check("R3 tstp set", 32'(status_o[4]), 1);
    // R4 read with a coincident capture keeps the bit
    stat_rd_i = 1; sof_i = 1;
    step(); stat_rd_i = 0; sof_i = 0;
    check("R4 event wins read", 32'(status_o[4]), 1);
    stat_rd_i = 1;
    step(); stat_rd_i = 0;
    check("R4 read clears tstp", 32'(status_o[4]), 0);
    // R3 eof ignored in sof mode
    t0 = timestamp_o; eof_i = 1;
    step(); eof_i = 0;
    check("R3 eof ignored stamp", 32'(timestamp_o), 32'(t0));
    check("R3 eof ignored tstp", 32'(status_o[4]), 0);
    // R3 capture on end of frame
    ts_on_eof_i = 1;
    step();
    sof_i = 1; step(); sof_i = 0;
    check("R3 sof ignored in eof mode", 32'(status_o[4]), 0);
    t0 = timer_o; eof_i = 1;
    step(); eof_i = 0;
    check("R3 eof stamp", 32'(timestamp_o), 32'(t0));
    check("R3 eof tstp", 32'(status_o[4]), 1);
    stat_rd_i = 1; step(); stat_rd_i = 0;

    // R6 sleep
    lp_req_i = 1; tx_pend_i = 1;
    step();
    check("R6 sleep blocked by pending tx", 32'(status_o[2]), 0);
    tx_pend_i = 0;
    step();
    check("R6 sleep set", 32'(status_o[2]), 1);
    stat_rd_i = 1; step(); stat_rd_i = 0;
    check("R6 sleep survives read", 32'(status_o[2]), 1);
    lp_req_i = 0;
    step();
    check("R6 sleep follows source", 32'(status_o[2]), 0);

    // R7 wake
    bus_sync_i = 1; step(); bus_sync_i = 0;
    check("R7 sync without wakeup ignored", 32'(status_o[1]), 0);
    wakeup_i = 1; step(); wakeup_i = 0;
    step();
    check("R7 wakeup alone", 32'(status_o[1]), 0);
    bus_sync_i = 1; step(); bus_sync_i = 0;
    check("R7 wake set", 32'(status_o[1]), 1);
    stat_rd_i = 1; step(); stat_rd_i = 0;
    check("R7 wake survives read", 32'(status_o[1]), 1);

    // R8 / R9 mask and irq (wake pending)
    check("R9 irq masked", 32'(irq_o), 0);
    imr_set_i = 5'b00010; step(); imr_set_i = 0;
    check("R8 mask set", 32'(imr_o), 32'h2);
    check("R9 irq raised", 32'(irq_o), 1);
    imr_set_i = 5'b10110; imr_clr_i = 5'b00110; step();
    imr_set_i = 0; imr_clr_i = 0;
    check("R8 clear wins", 32'(imr_o), 32'h10);
    check("R9 irq after clear", 32'(irq_o), 0);
    lp_req_i = 1; step(); lp_req_i = 0;
    check("R7 wake cleared by lp req", 32'(status_o[1]), 0);

    // R1 prescaler rate
    presc_i = 8'd3;
    t0 = timer_o;
    repeat (40) step();
    check("R1 prescaled rate", 32'(timer_o - t0), 10);

    // R1 / R2 wrap and overflow
    presc_i = 0;
    stat_rd_i = 1; step(); stat_rd_i = 0;
    while (timer_o != 16'hFFFF) step();
    check("R2 no ovf before wrap", 32'(status_o[3]), 0);
    step();
    check("R1 wrap to zero", 32'(timer_o), 0);
    check("R2 ovf set", 32'(status_o[3]), 1);
    check("R1 counts after wrap", 32'(timer_o), 0);
    imr_set_i = 5'b01000; step(); imr_set_i = 0;
    check("R9 irq on ovf", 32'(irq_o), 1);
    stat_rd_i = 1; step(); stat_rd_i = 0;
    check("R4 read clears ovf", 32'(status_o[3]), 0);
    check("R9 irq drops", 32'(irq_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule